// File: doc/BRIEF.md
# Two-Bit Branch Direction and Target Predictor

This block predicts conditional branches in the fetch stage of a pipelined processor. The fetch address picks one entry from two small tables that are indexed by the low bits of the word address. One table holds a four-state saturating confidence counter, which sets the taken/not-taken guess. The other table holds a destination address with a valid flag. When the entry is valid and its counter leans taken, fetch gets a taken prediction and the stored target. The tables carry no tags, so branches whose addresses share the index bits share one entry.

When a branch resolves later in the pipe, the execute stage presents the same address, the actual outcome and target, and the direction and target that fetch predicted for that branch. The block raises a combinational mispredict flag in that same cycle, which tells the pipeline to flush the in-flight instructions and refetch. At the next clock edge the block trains its counter and, for a taken branch only, its target.

Top module: `brp_top`

## Requirements
- R1: After reset every entry holds the weakly-not-taken counter state with its valid flag clear. For any fetch address `predTaken`=0, `predHit`=0 and `predTarget`=0.
- R2: The entry index is the address field `[OFFSET_BITS +: log2(ENTRIES)]`, which is bits [5:2] by default. Addresses that differ only outside that field select the same entry, and addresses that differ inside it select different entries.
- R3: An entry whose valid flag is clear always gives `predTaken`=0, `predHit`=0 and `predTarget`=0, whatever its counter holds.
- R4: The counter has four states, encoded 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. It moves one step up on a taken update and one step down on a not-taken update. A valid entry predicts taken exactly when the counter is 2 or 3. From strong taken, the prediction changes only after two not-taken outcomes in a row.
- R5: The counter saturates. A taken update in state 3 and a not-taken update in state 0 leave it unchanged.
- R6: An update with `updTaken`=1 writes `updTarget` into the entry and sets its valid flag. An update with `updTaken`=0 leaves the stored target and the valid flag unchanged.
- R7: `mispredict` is combinational. It is 1 exactly when `updValid`=1 and either `updPredTaken`≠`updTaken`, or both are 1 and `updPredTarget`≠`updTarget`. Otherwise it is 0.
- R8: Take a branch that resolves taken nine times and then not taken, repeated as a loop. After the first pass, each further pass of the loop mispredicts exactly once.
- R9: A fetch lookup in the same cycle as an update to the same entry returns the table contents from before the update. The update becomes visible in the next cycle.
- R10: While `updValid`=0 no table state changes, whatever the other update inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| fetchPc | input | ADDR_W | Address being fetched |
| predTaken | output | 1 | Predicted taken for fetchPc |
| predHit | output | 1 | Indexed entry holds a valid target |
| predTarget | output | ADDR_W | Stored target, zero when not valid |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch |
| updTarget | input | ADDR_W | Actual destination of the resolved branch |
| updPredTaken | input | 1 | Direction that fetch predicted for this branch |
| updPredTarget | input | ADDR_W | Target that fetch predicted for this branch |
| mispredict | output | 1 | Flush-and-refetch request for the resolved branch |

## Verification
The bench uses the default build: 16 entries, 32-bit addresses and two ignored offset bits, so the index field is bits [5:2]. With that field a low address such as 0x14 and an address that differs only in its upper bits land on the same entry, which makes the tagless aliasing directly observable. Sixteen entries also leave room for separate, untouched entries for the counter walk, the loop pattern, the invalid-entry case and the same-cycle read/write case, so each of these starts from the reset state.

// File: rtl/brp_pkg.sv
package brp_pkg;

  // Four-state confidence counter; the upper bit is the taken guess.
  typedef enum logic [1:0] {
    CNT_SNT = 2'd0,
    CNT_WNT = 2'd1,
    CNT_WT  = 2'd2,
    CNT_ST  = 2'd3
  } cntState_e;

  // Strobes from the control module to the table datapath.
  typedef struct packed {
    logic cntWr;   // train the counter of the update entry
    logic cntUp;   // direction of the training step
    logic tgtWr;   // write the target and set the valid flag
  } tblStrobe_t;

  function automatic cntState_e satStep(cntState_e cur, logic up);
    cntState_e nxt;
    if (up) nxt = (cur == CNT_ST)  ? CNT_ST  : cntState_e'(cur + 2'd1);
    else    nxt = (cur == CNT_SNT) ? CNT_SNT : cntState_e'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/brp_ctrl.sv
module brp_ctrl
  import brp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updPredTaken,
  input  logic [ADDR_W-1:0] updPredTarget,
  output tblStrobe_t        strb,
  output logic              mispredict
);

  logic dirWrong;
  logic tgtWrong;

  // Direction disagreement, or agreement on taken with a different target.
  always_comb begin
    dirWrong   = updPredTaken ^ updTaken;
    tgtWrong   = updPredTaken & updTaken & (updPredTarget != updTarget);
    mispredict = updValid & (dirWrong | tgtWrong);
  end

  always_comb begin
    strb.cntWr = updValid;
    strb.cntUp = updTaken;
    strb.tgtWr = updValid & updTaken;
  end

  // R7: an idle update port never requests a flush
  a_r7_idle_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !mispredict);

  // R7: a matching taken prediction with matching target never flushes
  a_r7_match_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPredTaken && updTaken && updPredTarget == updTarget) |-> !mispredict);

endmodule

// File: rtl/brp_datapath.sv
module brp_datapath
  import brp_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int ADDR_W      = 32,
  parameter int OFFSET_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  tblStrobe_t        strb,
  output logic              predTaken,
  output logic              predHit,
  output logic [ADDR_W-1:0] predTarget
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   fetchIdx;
  logic [IDX_W-1:0]   updIdx;
  logic [ENTRIES-1:0] entrySel;
  logic [ENTRIES-1:0] validVec;
  cntState_e          cntTab [ENTRIES];
  logic [ADDR_W-1:0]  tgtTab [ENTRIES];

  assign fetchIdx = fetchPc[OFFSET_BITS +: IDX_W];
  assign updIdx   = updPc[OFFSET_BITS +: IDX_W];

  // One-hot decode of the entry being trained.
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_sel
    assign entrySel[gi] = (updIdx == IDX_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        cntTab[e] <= CNT_WNT;
        tgtTab[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (entrySel[e] && strb.cntWr) cntTab[e] <= satStep(cntTab[e], strb.cntUp);
        if (entrySel[e] && strb.tgtWr) begin
          tgtTab[e]   <= updTarget;
          validVec[e] <= 1'b1;
        end
      end
    end
  end

  // Lookup reads the registered tables, so a same-cycle write is not seen.
  always_comb begin
    predHit    = validVec[fetchIdx];
    predTaken  = predHit & cntTab[fetchIdx][1];
    predTarget = predHit ? tgtTab[fetchIdx] : '0;
  end

  // R5: a taken step from strong taken stays strong taken
  a_r5_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntWr && strb.cntUp && cntTab[updIdx] == CNT_ST) |=> cntTab[$past(updIdx)] == CNT_ST);

  // R5: a not-taken step from strong not-taken stays there
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntWr && !strb.cntUp && cntTab[updIdx] == CNT_SNT) |=> cntTab[$past(updIdx)] == CNT_SNT);

  // R6: a target write lands the resolved destination and the valid flag
  a_r6_tgt_written: assert property (@(posedge clk) disable iff (!rstN)
    strb.tgtWr |=> (tgtTab[$past(updIdx)] == $past(updTarget)) && validVec[$past(updIdx)]);

  // R6: target writes only accompany a taken training step
  a_r6_tgt_only_taken: assert property (@(posedge clk) disable iff (!rstN)
    strb.tgtWr |-> (strb.cntWr && strb.cntUp));

  // R10: no update strobe, no change in validity
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntWr |=> $stable(validVec));

  // R6: valid flags never clear outside reset
  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(validVec) & ~validVec) == '0));

endmodule

// File: rtl/brp_top.sv
module brp_top
  import brp_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int ADDR_W      = 32,
  parameter int OFFSET_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              predTaken,
  output logic              predHit,
  output logic [ADDR_W-1:0] predTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updPredTaken,
  input  logic [ADDR_W-1:0] updPredTarget,
  output logic              mispredict
);

  tblStrobe_t strb;

  brp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updTarget     (updTarget),
    .updPredTaken  (updPredTaken),
    .updPredTarget (updPredTarget),
    .strb          (strb),
    .mispredict    (mispredict)
  );

  brp_datapath #(
    .ENTRIES     (ENTRIES),
    .ADDR_W      (ADDR_W),
    .OFFSET_BITS (OFFSET_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .updPc      (updPc),
    .updTarget  (updTarget),
    .strb       (strb),
    .predTaken  (predTaken),
    .predHit    (predHit),
    .predTarget (predTarget)
  );

  // R3: a taken guess only comes from a valid entry
  a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predHit);

  // R3: an invalid entry exposes no target
  a_r3_no_tgt_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (predTarget == '0));

endmodule

// File: tb/brp_top_test.sv
module brp_top_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] fetchPc;
  logic          predTaken, predHit;
  logic [AW-1:0] predTarget;
  logic          updValid, updTaken, updPredTaken;
  logic [AW-1:0] updPc, updTarget, updPredTarget;
  logic          mispredict;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  brp_top uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predTaken(predTaken), .predHit(predHit), .predTarget(predTarget),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .updPredTaken(updPredTaken), .updPredTarget(updPredTarget),
    .mispredict(mispredict)
  );

  // Vector: {actual taken, expected predicted taken, expected mispredict}
  localparam int NVEC = 12;
  localparam logic [2:0] seqVec [NVEC] = '{
    3'b101, 3'b110, 3'b110, 3'b011, 3'b110, 3'b011,
    3'b011, 3'b000, 3'b000, 3'b101, 3'b101, 3'b110
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One fetch of pc plus resolution of that same branch in the same cycle.
  task automatic step(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tgt,
                      output logic obsPred, output logic [AW-1:0] obsTgt, output logic obsMiss);
    @(negedge clk);
    fetchPc  = pc;
    updValid = 1'b0;
    #1;
    obsPred = predTaken;
    obsTgt  = predTarget;
    updValid = 1'b1; updPc = pc; updTaken = tk; updTarget = tgt;
    updPredTaken = obsPred; updPredTarget = obsTgt;
    #1;
    obsMiss = mispredict;
    @(posedge clk);
    #1;
    updValid = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] pc);
    @(negedge clk);
    fetchPc = pc;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic p, m;
    logic [AW-1:0] t;
    int missCnt;
    rstN = 1'b0; fetchPc = '0; updValid = 1'b0; updPc = '0; updTaken = 1'b0;
    updTarget = '0; updPredTaken = 1'b0; updPredTarget = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state on several entries
    for (int a = 0; a < 4; a++) begin
      look(AW'(32'h0000_0100 + a * 4));
      check("R1 predTaken", AW'(predTaken), 0);
      check("R1 predHit", AW'(predHit), 0);
      check("R1 predTarget", predTarget, 0);
    end

    // R4 R5 R7: counter walk on entry 0 from the vector table
    for (int v = 0; v < NVEC; v++) begin
      step(32'h0000_0100, seqVec[v][2], 32'h0000_4000, p, t, m);
      check("R4 predicted direction", AW'(p), AW'(seqVec[v][1]));
      check("R7 mispredict", AW'(m), AW'(seqVec[v][0]));
    end
    look(32'h0000_0100);
    check("R5 strong taken after walk", AW'(predTaken), 1);

    // R3: not-taken training alone leaves entry 3 invalid
    step(32'h0000_000C, 1'b0, 32'h0000_9999, p, t, m);
    step(32'h0000_000C, 1'b0, 32'h0000_9999, p, t, m);
    look(32'h0000_000C);
    check("R3 invalid hit", AW'(predHit), 0);
    check("R3 invalid taken", AW'(predTaken), 0);
    check("R3 invalid target", predTarget, 0);

    // R2 R6: taken write on entry 5, aliased and neighbouring lookups
    step(32'h1000_0014, 1'b1, 32'h0000_8000, p, t, m);
    look(32'h2000_0057);
    check("R2 alias hit", AW'(predHit), 1);
    check("R2 alias target", predTarget, 32'h0000_8000);
    check("R2 alias taken", AW'(predTaken), 1);
    look(32'h1000_0018);
    check("R2 neighbour miss", AW'(predHit), 0);

    // R6 R7: not-taken outcome keeps target, direction wrong flushes
    step(32'h1000_0014, 1'b0, 32'h0000_AAAA, p, t, m);
    check("R7 direction mispredict", AW'(m), 1);
    look(32'h1000_0014);
    check("R6 target kept", predTarget, 32'h0000_8000);
    check("R6 valid kept", AW'(predHit), 1);
    check("R4 weak not-taken", AW'(predTaken), 0);

    // R7 R6: taken to a new target flushes and overwrites
    step(32'h1000_0014, 1'b1, 32'h0000_8000, p, t, m);
    step(32'h1000_0014, 1'b1, 32'h0000_C000, p, t, m);
    check("R7 target mispredict", AW'(m), 1);
    look(32'h1000_0014);
    check("R6 target rewritten", predTarget, 32'h0000_C000);

    // R7 R10: idle update port with mismatching fields
    @(negedge clk);
    fetchPc = 32'h1000_0014;
    updPc = 32'h1000_0014; updTaken = 1'b0; updTarget = 32'h0000_1234;
    updPredTaken = 1'b1; updPredTarget = 32'h0000_5678; updValid = 1'b0;
    #1;
    check("R7 idle no flush", AW'(mispredict), 0);
    @(posedge clk);
    look(32'h1000_0014);
    check("R10 direction unchanged", AW'(predTaken), 1);
    check("R10 target unchanged", predTarget, 32'h0000_C000);

    // R9: same-cycle lookup sees old contents
    @(negedge clk);
    fetchPc = 32'h0000_001C;
    updValid = 1'b1; updPc = 32'h0000_001C; updTaken = 1'b1; updTarget = 32'h0000_7000;
    updPredTaken = 1'b0; updPredTarget = '0;
    #1;
    check("R9 old contents", AW'(predHit), 0);
    @(posedge clk);
    #1 updValid = 1'b0;
    look(32'h0000_001C);
    check("R9 update visible", predTarget, 32'h0000_7000);

    // R8: loop branch on entry 9, three passes of nine taken then one not taken
    for (int pass = 0; pass < 3; pass++) begin
      missCnt = 0;
      for (int it = 0; it < 10; it++) begin
        step(32'h0000_0124, (it < 9), 32'h0000_0100, p, t, m);
        if (m) missCnt++;
      end
      if (pass == 0) check("R8 first pass misses", AW'(missCnt), 2);
      else           check("R8 warm pass misses", AW'(missCnt), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule